// File: doc/BRIEF.md
# Host Data Bus Buffer Interface

This block is the slave side of an 8-bit host bus attached to an embedded controller. The host writes bytes into an input buffer and reads bytes from an output buffer. It can also read a status byte that reports both buffers' full flags, two handshake flags and a four-bit field set by the controller. The controller side reads the input buffer, loads the output buffer and sets the flag bits. It also turns on two optional features: host interrupt outputs and a DMA request/acknowledge handshake.

Host strobes, address, select lines and data are brought into the internal clock domain through a two-stage synchronizer. The select, address and data are captured while a strobe is low. Buffer and flag updates happen on the synchronized rising edge of the strobe. The data bus itself is modelled as an output-enable and output-data pair driven straight from the raw pins, so the host sees read data while its strobe is low.

Top module: `hbus_buffer`

## Requirements
- R1: After reset, the status byte reads 0x00. In addition, `drq` is 0, `irq_obf` is 0, `irq_ibf_n` is 1, and `ctl_ibuf` is 0.
- R2: A host write (`cs_n` low, `wr_n` pulsed low) loads `din` into the input buffer, which the controller sees on `ctl_ibuf`. It also sets IBF, which is status bit 1.
- R3: Every chip-select write copies `a0` into F1, status bit 3. This happens whether or not the controller ever reads the byte.
- R4: A host read with `a0`=1 returns the status byte {STS[7:4], F1, F0, IBF, OBF}. The read leaves every flag unchanged.
- R5: A controller pulse on `ctl_obuf_wr` loads the output buffer and sets OBF, status bit 0. A host read with `a0`=0 returns the output buffer and clears OBF.
- R6: A pulse on `ctl_ibuf_rd` clears IBF.
- R7: F0 (bit 2) and STS (bits 7:4) change only through `ctl_f0_wr` and `ctl_sts_wr`. Host writes and reads leave them as they were.
- R8: With `int_en`=1, `irq_obf` equals OBF and `irq_ibf_n` equals IBF, so it is low while the input buffer is free. With `int_en`=0, `irq_obf` is 0 and `irq_ibf_n` is 1.
- R9: With `dma_en`=1, a read under `dack_n` low with `cs_n` high returns the output buffer. It clears OBF and DRQ.
- R10: With `dma_en`=1, a write under `dack_n` low with `cs_n` high loads the input buffer. It sets IBF, clears DRQ and leaves F1 unchanged.
- R11: `ctl_drq_set` raises `drq` only while `dma_en`=1. `drq` stays high through host status reads.
- R12: `dout_oe` is 1 only while `rd_n` is low and either `cs_n` is low or `dack_n` is low with `dma_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| a0 | input | 1 | Host address bit: 1 = status/command, 0 = data |
| dack_n | input | 1 | DMA acknowledge, active low |
| din | input | DW | Host data bus, inbound |
| dout | output | DW | Host data bus, outbound |
| dout_oe | output | 1 | Outbound bus drive enable |
| int_en | input | 1 | Enable host interrupt outputs |
| dma_en | input | 1 | Enable DMA handshake |
| ctl_ibuf_rd | input | 1 | Controller reads input buffer (clears IBF) |
| ctl_ibuf | output | DW | Input buffer contents |
| ctl_obuf_wr | input | 1 | Controller loads output buffer |
| ctl_obuf_data | input | DW | Data for output buffer |
| ctl_f0_wr | input | 1 | Controller writes F0 |
| ctl_f0_val | input | 1 | New F0 value |
| ctl_sts_wr | input | 1 | Controller writes STS field |
| ctl_sts_val | input | DW-4 | New STS value |
| ctl_drq_set | input | 1 | Controller requests a DMA transfer |
| status | output | DW | Status byte as seen by the host |
| irq_obf | output | 1 | Output-buffer-full interrupt |
| irq_ibf_n | output | 1 | Input-buffer-free interrupt, active low |
| drq | output | 1 | DMA request |

## Verification
All 256 data values are written with `a0` taken from the low data bit, which catches an F1 that latches the wrong bit or is updated only when the byte is consumed. Status reads are repeated back to back; a design that treated them as data reads would clear OBF on the second read. DMA transfers run with `cs_n` held high, so a design that still required chip select would leave DRQ stuck and the buffer untouched. A DMA write lands on an F1 of each polarity, so a design that let DMA writes alter F1 would show a flipped bit 3. With `dma_en` low, a design that accepted `ctl_drq_set` or drove the bus on `dack_n` shows a high `drq` or `dout_oe`.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DMA  = 2'd3
    } sel_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= RST_VAL;
                else        stg_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= RST_VAL;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hbus_regs.sv
module hbus_regs
    import hbus_pkg::*;
#(
    parameter int DW = 8,
    localparam int SW = DW - 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic          a0_s,
    input  logic          dack_s,
    input  logic [DW-1:0] din_s,
    input  logic          dma_en,
    input  logic          ctl_ibuf_rd,
    input  logic          ctl_obuf_wr,
    input  logic [DW-1:0] ctl_obuf_data,
    input  logic          ctl_f0_wr,
    input  logic          ctl_f0_val,
    input  logic          ctl_sts_wr,
    input  logic [SW-1:0] ctl_sts_val,
    input  logic          ctl_drq_set,
    output logic [DW-1:0] ibuf,
    output logic [DW-1:0] obuf,
    output logic [DW-1:0] status,
    output logic          drq
);
    typedef struct packed {
        logic [DW-1:0] ibuf;
        logic [DW-1:0] obuf;
        logic          obf;
        logic          ibf;
        logic          f0;
        logic          f1;
        logic [SW-1:0] sts;
        logic          drq;
        logic          rd_p;
        logic          wr_p;
        sel_e          cap_sel;
        logic          cap_a0;
        logic [DW-1:0] cap_data;
    } state_t;

    state_t st_d, st_q;
    sel_e   sel_now;
    logic   wr_rise, rd_rise;

    always_comb begin
        if (!cs_s)                 sel_now = a0_s ? SEL_STAT : SEL_DATA;
        else if (!dack_s && dma_en) sel_now = SEL_DMA;
        else                       sel_now = SEL_NONE;
        wr_rise = wr_s && !st_q.wr_p;
        rd_rise = rd_s && !st_q.rd_p;
    end

    always_comb begin
        st_d      = st_q;
        st_d.rd_p = rd_s;
        st_d.wr_p = wr_s;
        if (!wr_s || !rd_s) begin
            st_d.cap_sel = sel_now;
            st_d.cap_a0  = a0_s;
        end
        if (!wr_s) st_d.cap_data = din_s;

        if (ctl_ibuf_rd) st_d.ibf = 1'b0;
        if (wr_rise && st_q.cap_sel != SEL_NONE) begin
            st_d.ibuf = st_q.cap_data;
            st_d.ibf  = 1'b1;
            if (st_q.cap_sel == SEL_DMA) st_d.drq = 1'b0;
            else                         st_d.f1  = st_q.cap_a0;
        end
        if (rd_rise && st_q.cap_sel == SEL_DATA) st_d.obf = 1'b0;
        if (rd_rise && st_q.cap_sel == SEL_DMA) begin
            st_d.obf = 1'b0;
            st_d.drq = 1'b0;
        end

        if (ctl_obuf_wr) begin
            st_d.obuf = ctl_obuf_data;
            st_d.obf  = 1'b1;
        end
        if (ctl_f0_wr)  st_d.f0  = ctl_f0_val;
        if (ctl_sts_wr) st_d.sts = ctl_sts_val;
        if (!dma_en)          st_d.drq = 1'b0;
        else if (ctl_drq_set) st_d.drq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rd_p    <= 1'b1;
            st_q.wr_p    <= 1'b1;
            st_q.cap_sel <= SEL_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ibuf   = st_q.ibuf;
    assign obuf   = st_q.obuf;
    assign status = {st_q.sts, st_q.f1, st_q.f0, st_q.ibf, st_q.obf};
    assign drq    = st_q.drq;

    // R2
    host_wr_sets_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && st_q.cap_sel != SEL_NONE) |=> st_q.ibf);

    // R5
    ctl_load_sets_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_obuf_wr |=> (st_q.obf && st_q.obuf == $past(ctl_obuf_data)));

    // R4
    stat_read_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && st_q.cap_sel == SEL_STAT && !wr_rise && !ctl_obuf_wr && !ctl_ibuf_rd)
        |=> ($stable(st_q.obf) && $stable(st_q.ibf) && $stable(st_q.f1)));

    // R9
    dma_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && st_q.cap_sel == SEL_DMA && !ctl_drq_set && !ctl_obuf_wr)
        |=> (!st_q.drq && !st_q.obf));

    // R7
    f0_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_f0_wr |=> $stable(st_q.f0));
endmodule

// File: rtl/hbus_buffer.sv
module hbus_buffer
    import hbus_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 2,
    localparam int SW    = DW - 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          a0,
    input  logic          dack_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    input  logic          int_en,
    input  logic          dma_en,
    input  logic          ctl_ibuf_rd,
    output logic [DW-1:0] ctl_ibuf,
    input  logic          ctl_obuf_wr,
    input  logic [DW-1:0] ctl_obuf_data,
    input  logic          ctl_f0_wr,
    input  logic          ctl_f0_val,
    input  logic          ctl_sts_wr,
    input  logic [SW-1:0] ctl_sts_val,
    input  logic          ctl_drq_set,
    output logic [DW-1:0] status,
    output logic          irq_obf,
    output logic          irq_ibf_n,
    output logic          drq
);
    logic [4:0]    ctl_s;
    logic [DW-1:0] din_s;
    logic [DW-1:0] obuf;

    hbus_sync #(.W(5), .STAGES(STAGES), .RST_VAL(5'b11101)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, rd_n, wr_n, a0, dack_n}),
        .q(ctl_s)
    );

    hbus_sync #(.W(DW), .STAGES(STAGES), .RST_VAL('0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
    );

    hbus_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cs_s(ctl_s[4]), .rd_s(ctl_s[3]), .wr_s(ctl_s[2]),
        .a0_s(ctl_s[1]), .dack_s(ctl_s[0]), .din_s(din_s),
        .dma_en(dma_en),
        .ctl_ibuf_rd(ctl_ibuf_rd),
        .ctl_obuf_wr(ctl_obuf_wr), .ctl_obuf_data(ctl_obuf_data),
        .ctl_f0_wr(ctl_f0_wr), .ctl_f0_val(ctl_f0_val),
        .ctl_sts_wr(ctl_sts_wr), .ctl_sts_val(ctl_sts_val),
        .ctl_drq_set(ctl_drq_set),
        .ibuf(ctl_ibuf), .obuf(obuf), .status(status), .drq(drq)
    );

    always_comb begin
        dout_oe   = !rd_n && (!cs_n || (!dack_n && dma_en));
        dout      = (!cs_n && a0) ? status : obuf;
        irq_obf   = int_en && status[0];
        irq_ibf_n = !(int_en && !status[1]);
    end

    // R12
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!rd_n && (!cs_n || !dack_n)));
endmodule

// File: tb/sim_hbus_buffer.sv
module sim_hbus_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, dack_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic       int_en = 1'b0, dma_en = 1'b0;
    logic       ctl_ibuf_rd = 1'b0, ctl_obuf_wr = 1'b0;
    logic [7:0] ctl_ibuf, ctl_obuf_data = 8'h00;
    logic       ctl_f0_wr = 1'b0, ctl_f0_val = 1'b0, ctl_sts_wr = 1'b0;
    logic [3:0] ctl_sts_val = 4'h0;
    logic       ctl_drq_set = 1'b0;
    logic [7:0] status;
    logic       irq_obf, irq_ibf_n, drq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of the flags, built from the requirements
    logic       m_obf = 0, m_ibf = 0, m_f0 = 0, m_f1 = 0;
    logic [3:0] m_sts = 0;

    always #2.5 clk = ~clk;

    hbus_buffer u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .dack_n(dack_n), .din(din), .dout(dout), .dout_oe(dout_oe),
        .int_en(int_en), .dma_en(dma_en), .ctl_ibuf_rd(ctl_ibuf_rd),
        .ctl_ibuf(ctl_ibuf), .ctl_obuf_wr(ctl_obuf_wr), .ctl_obuf_data(ctl_obuf_data),
        .ctl_f0_wr(ctl_f0_wr), .ctl_f0_val(ctl_f0_val), .ctl_sts_wr(ctl_sts_wr),
        .ctl_sts_val(ctl_sts_val), .ctl_drq_set(ctl_drq_set), .status(status),
        .irq_obf(irq_obf), .irq_ibf_n(irq_ibf_n), .drq(drq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] m_stat();
        return {m_sts, m_f1, m_f0, m_ibf, m_obf};
    endfunction

    task automatic host_wr(input logic [7:0] d, input logic a, input bit dma);
        @(negedge clk);
        if (dma) dack_n = 1'b0; else cs_n = 1'b0;
        a0 = a; din = d;
        cyc(1); wr_n = 1'b0;
        cyc(4); wr_n = 1'b1;
        cyc(1); cs_n = 1'b1; dack_n = 1'b1;
        cyc(6);
    endtask

    task automatic host_rd(input logic a, input bit dma, output logic [7:0] d, output logic oe);
        @(negedge clk);
        if (dma) dack_n = 1'b0; else cs_n = 1'b0;
        a0 = a;
        cyc(1); rd_n = 1'b0;
        cyc(2); d = dout; oe = dout_oe;
        cyc(2); rd_n = 1'b1;
        cyc(1); cs_n = 1'b1; dack_n = 1'b1;
        cyc(6);
    endtask

    task automatic pulse_ibuf_rd();
        @(negedge clk); ctl_ibuf_rd = 1'b1; cyc(1); ctl_ibuf_rd = 1'b0; cyc(1);
    endtask

    task automatic pulse_obuf(input logic [7:0] d);
        @(negedge clk); ctl_obuf_data = d; ctl_obuf_wr = 1'b1; cyc(1); ctl_obuf_wr = 1'b0; cyc(1);
    endtask

    task automatic pulse_drq();
        @(negedge clk); ctl_drq_set = 1'b1; cyc(1); ctl_drq_set = 1'b0; cyc(1);
    endtask

    task automatic check_irq(input string tag);
        chk(irq_obf == (int_en & m_obf), tag, irq_obf, int_en & m_obf);
        chk(irq_ibf_n == (int_en ? m_ibf : 1'b1), tag, irq_ibf_n, int_en ? m_ibf : 1'b1);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        cyc(3); rst_n = 1'b1; cyc(2);

        // R1 reset state
        chk(status == 8'h00, "R1 status", status, 0);
        chk(drq == 1'b0, "R1 drq", drq, 0);
        chk(irq_obf == 1'b0 && irq_ibf_n == 1'b1, "R1 irq", {irq_obf, irq_ibf_n}, 2'b01);
        chk(ctl_ibuf == 8'h00, "R1 ibuf", ctl_ibuf, 0);
        chk(dout_oe == 1'b0, "R12 idle", dout_oe, 0);

        for (int d = 0; d < 256; d++) begin
            logic [7:0] v = d[7:0];
            if (v[3:0] == 4'h5) begin
                @(negedge clk);
                ctl_sts_wr = 1'b1; ctl_sts_val = v[7:4];
                ctl_f0_wr = 1'b1;  ctl_f0_val = v[6];
                cyc(1); ctl_sts_wr = 1'b0; ctl_f0_wr = 1'b0;
                m_sts = v[7:4]; m_f0 = v[6];
            end
            int_en = v[1];
            host_wr(v, v[0], 1'b0);
            m_ibf = 1'b1; m_f1 = v[0];
            chk(ctl_ibuf == v, "R2 ibuf", ctl_ibuf, v);
            chk(status[1] == 1'b1, "R2 ibf", status[1], 1);
            chk(status[3] == v[0], "R3 f1", status[3], v[0]);
            chk(status[7:4] == m_sts && status[2] == m_f0, "R7 f0/sts", status, m_stat());
            check_irq("R8 after write");
            host_rd(1'b1, 1'b0, rd, oe);
            chk(rd == m_stat(), "R4 status read", rd, m_stat());
            chk(oe == 1'b1, "R12 oe on read", oe, 1);
            if (v[2]) begin
                pulse_ibuf_rd(); m_ibf = 1'b0;
                chk(status[1] == 1'b0, "R6 ibf clear", status[1], 0);
            end
            pulse_obuf(~v); m_obf = 1'b1;
            host_rd(1'b1, 1'b0, rd, oe);
            chk(rd == m_stat(), "R4 status with obf", rd, m_stat());
            host_rd(1'b1, 1'b0, rd, oe);
            chk(rd == m_stat(), "R4 repeated status", rd, m_stat());
            check_irq("R8 obf set");
            host_rd(1'b0, 1'b0, rd, oe);
            chk(rd == ~v, "R5 data read", rd, ~v);
            m_obf = 1'b0;
            chk(status == m_stat(), "R5 obf clear", status, m_stat());
            check_irq("R8 obf clear");
        end
        pulse_ibuf_rd(); m_ibf = 1'b0;

        // DMA disabled: request and acknowledge have no effect
        dma_en = 1'b0;
        pulse_drq();
        chk(drq == 1'b0, "R11 drq ignored", drq, 0);
        pulse_obuf(8'h3c); m_obf = 1'b1;
        host_rd(1'b0, 1'b1, rd, oe);
        chk(oe == 1'b0, "R12 dack ignored", oe, 0);
        chk(status == m_stat(), "R12 obf kept", status, m_stat());
        @(negedge clk); rd_n = 1'b0; cyc(2);
        chk(dout_oe == 1'b0, "R12 no select", dout_oe, 0);
        rd_n = 1'b1; cyc(6);
        host_rd(1'b0, 1'b0, rd, oe); m_obf = 1'b0;

        dma_en = 1'b1;
        for (int b = 4; b >= 1; b--) begin
            pulse_obuf(8'(b * 8'h11)); m_obf = 1'b1;
            pulse_drq();
            chk(drq == 1'b1, "R11 drq set", drq, 1);
            host_rd(1'b1, 1'b0, rd, oe);
            chk(rd == m_stat(), "R4 status in dma", rd, m_stat());
            chk(drq == 1'b1, "R11 drq held", drq, 1);
            host_rd(1'b0, 1'b1, rd, oe);
            chk(rd == 8'(b * 8'h11), "R9 dma read data", rd, b * 8'h11);
            chk(oe == 1'b1, "R12 dma oe", oe, 1);
            m_obf = 1'b0;
            chk(drq == 1'b0, "R9 drq clear", drq, 0);
            chk(status == m_stat(), "R9 obf clear", status, m_stat());
        end
        for (int b = 4; b >= 1; b--) begin
            host_wr(8'(b), b[0], 1'b0); m_f1 = b[0]; m_ibf = 1'b1;
            pulse_ibuf_rd(); m_ibf = 1'b0;
            pulse_drq();
            host_wr(8'(8'hA0 + b), ~b[0], 1'b1); m_ibf = 1'b1;
            chk(ctl_ibuf == 8'(8'hA0 + b), "R10 dma write data", ctl_ibuf, 8'hA0 + b);
            chk(drq == 1'b0, "R10 drq clear", drq, 0);
            chk(status == m_stat(), "R10 f1 kept", status, m_stat());
            pulse_ibuf_rd(); m_ibf = 1'b0;
        end
        report();
    end
endmodule